// File: doc/BRIEF.md
# Management PHY Register Responder

This block stands in for the register set of an Ethernet PHY that is managed through a command/data register pair. Software first places a value in the data register, then writes a command word. The command word names a PHY address, a register index and a direction. The block keeps its own control and advertisement registers. It reports a status word whose link bit follows a live input, and it returns fixed identifier and link-partner values. Serial MDIO bit timing and real autonegotiation are outside the block.

A command whose address field equals the configured PHY address acts on the PHY; any other command is only stored. A read command loads the selected PHY register into the data register at the same clock edge that stores the command. A write command takes its value from the data register as it stands.

Top module: `phy_mgmt_responder`

## Requirements
- R1: A write with `wr_sel`=0 stores `wr_data` as the command word with bit 0 forced to 0. Its fields are: PHY address in bits 15:12, register index in bits 7:4, bit 1 = 1 for a PHY write and 0 for a PHY read.
- R2: A write with `wr_sel`=1 stores `wr_data` unchanged in the data register. `rd_data` shows the data register when `rd_sel`=1 and the command word when `rd_sel`=0.
- R3: A command whose address field differs from `phy_addr_cfg` changes neither the data register nor any PHY register.
- R4: After reset, the command and data registers read 0, the control register (index 0) reads 0x3100 and the advertisement register (index 4) reads 0.
- R5: The status register (index 1) reads 0xFE28 with bit 2 replaced by `link_up`.
- R6: A PHY write to index 0 whose data has bit 15 clear stores data bits 15:0 with bits 15 and 9 forced to 0.
- R7: A PHY write to index 0 whose data has bit 15 set returns control to 0x3100 and advertisement to 0, and the status link bit still follows `link_up`.
- R8: A PHY write to index 4 stores data bits 15:0, and these bits read back unchanged.
- R9: Indexes 2, 3 and 5 read 0x0044, 0x1400 and 0x0DE0. PHY writes to indexes 1, 2, 3, 5 and 6 to 15 change nothing.
- R10: A PHY read of an index from 6 to 15 loads 0 into the data register.
- R11: A PHY read puts the 16-bit register value, zero-extended, in the data register at the same edge that stores the command. A PHY write leaves the data register unchanged.
- R12: A change on `link_up` at any time shows in the status value of the next PHY read, with nothing held from earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_addr_cfg | input | 4 | PHY address this responder answers to |
| link_up | input | 1 | Live link state, feeds status bit 2 |
| wr_en | input | 1 | Register-bus write strobe |
| wr_sel | input | 1 | Write target: 0 = command, 1 = data |
| wr_data | input | 32 | Register-bus write value |
| rd_sel | input | 1 | Read source: 0 = command, 1 = data |
| rd_data | output | 32 | Register-bus read value |

## Verification
The bench uses the default field widths: a 4-bit PHY address and a 4-bit register index. This keeps the command space small enough to sweep every address against every index. It runs that sweep for three configured addresses, 0, 5 and 15, so that both ends and a middle value are compared against every other address. The link input is toggled between commands in the sweep. Every index is also written with all ones, to confirm that only the control and advertisement registers ever change.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int BUS_W      = 32;
    localparam int MII_W      = 16;

    // Command word layout
    localparam int ADDR_LSB   = 12;
    localparam int ADDR_W     = 4;
    localparam int IDX_LSB    = 4;
    localparam int IDX_W      = 4;
    localparam int DIR_BIT    = 1;
    localparam int BUSY_BIT   = 0;

    // PHY register indexes
    localparam logic [IDX_W-1:0] IDX_CTRL    = 4'd0;
    localparam logic [IDX_W-1:0] IDX_STAT    = 4'd1;
    localparam logic [IDX_W-1:0] IDX_ID_HI   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_ID_LO   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_ADV     = 4'd4;
    localparam logic [IDX_W-1:0] IDX_PARTNER = 4'd5;

    // Fixed values and masks
    localparam logic [MII_W-1:0] CTRL_DEFAULT  = 16'h3100;
    localparam logic [MII_W-1:0] STAT_BASE     = 16'hFE28;
    localparam logic [MII_W-1:0] ID_HI_VALUE   = 16'h0044;
    localparam logic [MII_W-1:0] ID_LO_VALUE   = 16'h1400;
    localparam logic [MII_W-1:0] PARTNER_VALUE = 16'h0DE0;
    localparam logic [MII_W-1:0] CTRL_SELFCLR  = 16'h8200;
    localparam int               CTRL_RST_BIT  = 15;
    localparam int               LINK_BIT      = 2;

    typedef struct packed {
        logic             hit;
        logic             is_write;
        logic [IDX_W-1:0] idx;
    } phy_cmd_t;

    typedef struct packed {
        logic [MII_W-1:0] ctrl;
        logic [MII_W-1:0] adv;
    } phy_state_t;

    typedef struct packed {
        logic [BUS_W-1:0] cmd;
        logic [BUS_W-1:0] data;
    } host_regs_t;

endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
    import phy_mgmt_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int I_W = IDX_W
) (
    input  logic           valid,
    input  logic [A_W-1:0] addr_field,
    input  logic [I_W-1:0] idx_field,
    input  logic           dir_field,
    input  logic [A_W-1:0] own_addr,
    output phy_cmd_t       cmd
);

    always_comb begin
        cmd.hit      = valid && (addr_field == own_addr);
        cmd.is_write = dir_field;
        cmd.idx      = idx_field;
    end

endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
    import phy_mgmt_pkg::*;
#(
    parameter int W   = MII_W,
    parameter int I_W = IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_stb,
    input  logic [I_W-1:0] idx,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   ctrl,
    output logic [W-1:0]   adv
);

    phy_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            case (idx)
                IDX_CTRL: begin
                    if (wdata[CTRL_RST_BIT]) begin
                        state_d.ctrl = CTRL_DEFAULT;
                        state_d.adv  = '0;
                    end else begin
                        state_d.ctrl = wdata & ~CTRL_SELFCLR;
                    end
                end
                IDX_ADV:  state_d.adv = wdata;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ctrl <= CTRL_DEFAULT;
            state_q.adv  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl = state_q.ctrl;
    assign adv  = state_q.adv;

endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
    import phy_mgmt_pkg::*;
#(
    parameter int W   = MII_W,
    parameter int I_W = IDX_W
) (
    input  logic [I_W-1:0] idx,
    input  logic [W-1:0]   ctrl,
    input  logic [W-1:0]   adv,
    input  logic           link,
    output logic [W-1:0]   value
);

    logic [W-1:0] stat_word;

    always_comb begin
        stat_word           = STAT_BASE;
        stat_word[LINK_BIT] = link;
    end

    always_comb begin
        case (idx)
            IDX_CTRL:    value = ctrl;
            IDX_STAT:    value = stat_word;
            IDX_ID_HI:   value = ID_HI_VALUE;
            IDX_ID_LO:   value = ID_LO_VALUE;
            IDX_ADV:     value = adv;
            IDX_PARTNER: value = PARTNER_VALUE;
            default:     value = '0;
        endcase
    end

endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr_cfg,
    input  logic              link_up,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int PAD_W = BUS_W - MII_W;

    host_regs_t       host_d, host_q;
    phy_cmd_t         cmd;
    logic [MII_W-1:0] ctrl_val;
    logic [MII_W-1:0] adv_val;
    logic [MII_W-1:0] rd_value;
    logic             cmd_wr;
    logic [BUS_W-1:0] cmd_word;
    logic [BUS_W-1:0] data_word;

    assign cmd_wr = wr_en && !wr_sel;

    phy_cmd_decode #(.A_W(ADDR_W), .I_W(IDX_W)) u_decode (
        .valid      (cmd_wr),
        .addr_field (wr_data[ADDR_LSB +: ADDR_W]),
        .idx_field  (wr_data[IDX_LSB +: IDX_W]),
        .dir_field  (wr_data[DIR_BIT]),
        .own_addr   (phy_addr_cfg),
        .cmd        (cmd)
    );

    phy_reg_file #(.W(MII_W), .I_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (cmd.hit && cmd.is_write),
        .idx    (cmd.idx),
        .wdata  (host_q.data[MII_W-1:0]),
        .ctrl   (ctrl_val),
        .adv    (adv_val)
    );

    phy_read_mux #(.W(MII_W), .I_W(IDX_W)) u_rmux (
        .idx   (cmd.idx),
        .ctrl  (ctrl_val),
        .adv   (adv_val),
        .link  (link_up),
        .value (rd_value)
    );

    always_comb begin
        host_d = host_q;
        if (wr_en) begin
            if (!wr_sel) begin
                host_d.cmd           = wr_data;
                host_d.cmd[BUSY_BIT] = 1'b0;
                if (cmd.hit && !cmd.is_write) begin
                    host_d.data = {{PAD_W{1'b0}}, rd_value};
                end
            end else begin
                host_d.data = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= '0;
        end else begin
            host_q <= host_d;
        end
    end

    assign cmd_word  = host_q.cmd;
    assign data_word = host_q.data;
    assign rd_data   = rd_sel ? data_word : cmd_word;

endmodule

// File: rtl/phy_mgmt_responder_chk.sv
module phy_mgmt_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  phy_addr_cfg,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] cmd_word,
    input logic [31:0] data_word,
    input logic [15:0] ctrl_val,
    input logic [15:0] adv_val
);

    logic cmd_go, own, own_rd, own_wr;
    assign cmd_go = wr_en && !wr_sel;
    assign own    = cmd_go && (wr_data[15:12] == phy_addr_cfg);
    assign own_rd = own && !wr_data[1];
    assign own_wr = own && wr_data[1];

    a_r1_busy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> (cmd_word[0] == 1'b0) && (cmd_word[31:1] == $past(wr_data[31:1])));

    a_r3_foreign_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !own) |=> $stable(ctrl_val) && $stable(adv_val) && $stable(data_word));

    a_r6_ctrl_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (own_wr && wr_data[7:4] == 4'd0 && !data_word[15])
        |=> ctrl_val == ($past(data_word[15:0]) & 16'h7DFF));

    a_r7_ctrl_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (own_wr && wr_data[7:4] == 4'd0 && data_word[15])
        |=> (ctrl_val == 16'h3100) && (adv_val == 16'h0000));

    a_r9_id_high_value: assert property (@(posedge clk) disable iff (!rst_n)
        (own_rd && wr_data[7:4] == 4'd2) |=> data_word == 32'h0000_0044);

    a_r10_unknown_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (own_rd && wr_data[7:4] > 4'd5) |=> data_word == 32'h0);

    a_r11_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        own_wr |=> $stable(data_word));

endmodule

bind phy_mgmt_responder phy_mgmt_responder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_addr_cfg (phy_addr_cfg),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .cmd_word     (cmd_word),
    .data_word    (data_word),
    .ctrl_val     (ctrl_val),
    .adv_val      (adv_val)
);

// File: tb/phy_mgmt_responder_tb.sv
`timescale 1ns/1ps
module phy_mgmt_responder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  phy_addr_cfg = 4'd5;
    logic        link_up = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ctrl = 16'h3100;
    logic [15:0] m_adv  = 16'h0000;
    logic [31:0] m_data = '0;

    always #10 clk = ~clk;

    phy_mgmt_responder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .phy_addr_cfg (phy_addr_cfg),
        .link_up      (link_up),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_value(input logic [3:0] idx);
        case (idx)
            4'd0: model_value = m_ctrl;
            4'd1: model_value = 16'hFE28 | (16'(link_up) << 2);
            4'd2: model_value = 16'h0044;
            4'd3: model_value = 16'h1400;
            4'd4: model_value = m_adv;
            4'd5: model_value = 16'h0DE0;
            default: model_value = 16'h0000;
        endcase
    endfunction

    task automatic bus_write(input logic sel, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic read_port(input logic sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Issue a command, update the model, and check command and data registers.
    task automatic do_cmd(input logic [3:0] a, input logic [3:0] idx, input logic wr, input string req);
        logic [31:0] word, got;
        word = 32'hA5C0_0000 | (32'(a) << 12) | (32'(idx) << 4) | 32'h0000_0F0C
             | (32'(wr) << 1) | 32'h1;
        if (a == phy_addr_cfg) begin
            if (wr) begin
                if (idx == 4'd0) begin
                    if (m_data[15]) begin m_ctrl = 16'h3100; m_adv = 16'h0; end
                    else m_ctrl = m_data[15:0] & 16'h7DFF;
                end else if (idx == 4'd4) begin
                    m_adv = m_data[15:0];
                end
            end else begin
                m_data = {16'h0, model_value(idx)};
            end
        end
        bus_write(1'b0, word);
        read_port(1'b0, got);
        check("R1", got, word & 32'hFFFF_FFFE);
        read_port(1'b1, got);
        check(req, got, m_data);
    endtask

    task automatic set_data(input logic [31:0] v);
        logic [31:0] got;
        m_data = v;
        bus_write(1'b1, v);
        read_port(1'b1, got);
        check("R2", got, v);
    endtask

    task automatic read_reg(input logic [3:0] idx, input string req);
        do_cmd(phy_addr_cfg, idx, 1'b0, req);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R4: reset state
        read_port(1'b0, got); check("R4", got, 32'h0);
        read_port(1'b1, got); check("R4", got, 32'h0);
        read_reg(4'd0, "R4");
        read_reg(4'd4, "R4");
        read_reg(4'd1, "R5");

        // Sweep of every address against every index for three configurations
        foreach (phy_addr_cfg[k]) begin end
        for (int c = 0; c < 3; c++) begin
            phy_addr_cfg = (c == 0) ? 4'd0 : (c == 1) ? 4'd5 : 4'd15;
            for (int a = 0; a < 16; a++) begin
                for (int r = 0; r < 16; r++) begin
                    string req;
                    link_up = a[0] ^ r[0] ^ c[0];   // R12: link changes between commands
                    set_data(32'h5A00_0000 | (32'(a) << 8) | 32'(r));
                    if (4'(a) != phy_addr_cfg) req = "R3";
                    else if (r == 1) req = "R12";
                    else if (r > 5) req = "R10";
                    else if (r == 0 || r == 4) req = "R11";
                    else req = "R9";
                    do_cmd(4'(a), 4'(r), 1'b0, req);
                end
            end
        end

        phy_addr_cfg = 4'd5;
        // R6: masking of self-clearing bits
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_7FFF : (p == 1) ? 32'h0000_0200 :
                  (p == 2) ? 32'h0000_1340 : 32'h0000_0000;
            set_data(pat);
            do_cmd(4'd5, 4'd0, 1'b1, "R11");
            read_reg(4'd0, "R6");
        end
        // R8: advertisement store
        set_data(32'h1234_ABCD);
        do_cmd(4'd5, 4'd4, 1'b1, "R11");
        read_reg(4'd4, "R8");
        // R3: foreign write leaves registers alone
        set_data(32'h0000_0000);
        do_cmd(4'd6, 4'd0, 1'b1, "R3");
        do_cmd(4'd6, 4'd4, 1'b1, "R3");
        read_reg(4'd0, "R3");
        read_reg(4'd4, "R3");
        // R9: writes to other indexes change nothing
        for (int r = 1; r < 16; r++) begin
            if (r != 4) begin
                set_data(32'hFFFF_FFFF);
                do_cmd(4'd5, 4'(r), 1'b1, "R9");
                read_reg(4'(r), "R9");
                read_reg(4'd0, "R9");
                read_reg(4'd4, "R9");
            end
        end
        // R7: soft reset of PHY keeps live link
        link_up = 1'b0;
        set_data(32'h0000_8000 | 32'h0000_0A0A);
        do_cmd(4'd5, 4'd0, 1'b1, "R7");
        read_reg(4'd0, "R7");
        read_reg(4'd4, "R7");
        read_reg(4'd1, "R7");
        link_up = 1'b1;
        read_reg(4'd1, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule